// File: doc/BRIEF.md
# I2C Memory Transfer Sequencer

This block runs whole transfers against I2C memories and register devices. It sits on top of a byte-level bus engine that handles bit timing. It breaks each request into a chain of engine commands: bus start, bus stop, byte write and byte read. It also gathers the results into a small set of status pins. A caller gives a 7-bit device address, a memory offset of zero, one or two bytes, a byte count and a transfer kind (write, read or presence probe), then pulses `start`.

Write data enters and read data leaves on valid/ready streams. A write byte is taken only on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only while the sequencer is offering that byte to the engine and the engine is ready. The sender must hold `wr_valid` and `wr_data` steady until that cycle. A read byte stays on `rd_data` with `rd_valid` high until `rd_ready` is seen. While the byte waits, no further engine command is issued, so a slow consumer stalls the bus transfer.

The engine command channel uses the same valid/ready rules. After each accepted command the sequencer waits for a one-cycle `rsp_valid` before it issues the next one. Any offset bits above the bytes actually sent are masked by a parameter and ORed into the device address. With this, a part with more storage than one offset byte can reach looks like several 256-byte devices.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `busy`, `done`, `cmd_valid`, `rd_valid` and `wr_ready` are low. Command codes on `cmd_op` are 0 = bus start, 1 = bus stop, 2 = byte write, 3 = byte read.
- R2: A write or read with nonzero offset length opens with a bus start, then a byte write of the device address in bits 7:1 with bit 0 = 0. If that byte is NACKed, a bus stop follows, `err` is set and no more commands are issued.
- R3: Offset bytes follow as byte writes, most significant byte first, one per unit of offset length. A NACK on any offset byte ends the transfer with `err` set and no bus stop.
- R4: A read with nonzero offset length issues a bus stop and a new bus start after the last offset byte. It then issues a byte write of the device address with bit 0 = 1. The ACK of that byte is ignored.
- R5: A read with offset length zero goes from the first bus start straight to the device address byte with bit 0 = 1.
- R6: A read issues one byte-read command per requested byte. `cmd_nack` is 0 on all of them except the last, where it is 1. A bus stop follows and `err` stays low. Each returned byte is delivered in order on the read stream and held while `rd_ready` is low.
- R7: In a write, each data byte comes from the write stream. A NACKed data byte adds one to `fail_cnt`, and the remaining bytes are still sent. A bus stop ends the transfer and `err` stays low.
- R8: For writes and reads, the device address sent on the bus is `chip_addr` ORed with (`mem_addr` shifted right by 8 × `addr_len`) masked by `OVF_MASK`.
- R9: `xfer_op` encodes 0 = write, 1 = read, 2 = probe. A probe issues a bus start, the unmodified device address with bit 0 = 1, and a bus stop. `present` is set if that byte was ACKed.
- R10: A `start` pulse while `busy` is high is ignored and does not change the command sequence in progress.
- R11: `busy` rises in the cycle after an accepted `start`. `done` is high for exactly one cycle at the end of each transfer, and `busy` is low in the cycle after it.
- R12: While `cmd_valid` is high and `cmd_ready` is low, `cmd_op`, `cmd_data` and `cmd_nack` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| xfer_op | input | 2 | 0 write, 1 read, 2 probe |
| chip_addr | input | 7 | 7-bit device address |
| mem_addr | input | MADDR_W | Memory offset |
| addr_len | input | 2 | Offset bytes to send, 0 to 2 |
| xfer_len | input | LEN_W | Data byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Device or offset byte was NACKed |
| present | output | 1 | Probe result: device answered |
| fail_cnt | output | LEN_W | NACKed data bytes of the last write |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes read byte |
| rd_data | output | 8 | Read byte |
| cmd_valid | output | 1 | Engine command offered |
| cmd_ready | input | 1 | Engine accepts command |
| cmd_op | output | 2 | Engine command code |
| cmd_data | output | 8 | Byte to write |
| cmd_nack | output | 1 | For byte reads: 1 = NACK the byte |
| rsp_valid | input | 1 | Engine finished the last command |
| rsp_nack | input | 1 | Byte write was not acknowledged |
| rsp_data | input | 8 | Byte read from the bus |

## Verification
A wrong phase register shows up on the command port at the next command the engine accepts. It appears as a missing bus stop, an extra bus start, or a device address byte with the wrong direction bit. The bench therefore logs every command and compares the whole ordered list against its own model. A miscounted length or offset index shows at the end of the transfer, as one read or write too many or too few, or an offset byte out of order. A wrong status update shows on `err`, `fail_cnt` or `present` in the same cycle that `done` pulses.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [1:0] {
    ENG_START = 2'b00,
    ENG_STOP  = 2'b01,
    ENG_WRITE = 2'b10,
    ENG_READ  = 2'b11
  } eng_op_t;

  typedef enum logic [1:0] {
    XF_WRITE = 2'b00,
    XF_READ  = 2'b01,
    XF_PROBE = 2'b10
  } xfer_op_t;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START1, PH_CHIPW, PH_ADDR, PH_MIDSTOP, PH_START2,
    PH_CHIPR, PH_RDATA, PH_RDOUT, PH_WDATA, PH_ENDSTOP, PH_DONE
  } phase_t;
endpackage

// File: rtl/i2cs_addr_fold.sv
module i2cs_addr_fold #(
  parameter int         MADDR_W  = 24,
  parameter logic [6:0] OVF_MASK = 7'h03
) (
  input  logic [6:0]         chip,
  input  logic [MADDR_W-1:0] maddr,
  input  logic [1:0]         alen,
  input  logic [1:0]         idx,
  output logic [6:0]         chip_out,
  output logic [7:0]         addr_byte
);
  localparam int NBYTES = (MADDR_W + 7) / 8;
  localparam int PADW   = NBYTES * 8;

  logic [PADW-1:0] padded;
  logic [7:0]      lanes [NBYTES];
  logic [6:0]      high_bits;

  assign padded = PADW'(maddr);

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lanes[g] = padded[g*8 +: 8];
  end

  // bits left over above the offset bytes that go on the bus
  assign high_bits = 7'(padded >> {alen, 3'b000});
  assign chip_out  = chip | (high_bits & OVF_MASK);

  always_comb begin
    addr_byte = 8'h00;
    for (int b = 0; b < NBYTES; b++) begin
      if (idx == 2'(b)) addr_byte = lanes[b];
    end
  end
endmodule

// File: rtl/i2cs_nack_tally.sv
module i2cs_nack_tally #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         hit,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else if (hit && count != TOP) count <= count + W'(1);
  end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2cs_pkg::*;
#(
  parameter int         MADDR_W  = 24,
  parameter int         LEN_W    = 8,
  parameter logic [6:0] OVF_MASK = 7'h03
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         xfer_op,
  input  logic [6:0]         chip_addr,
  input  logic [MADDR_W-1:0] mem_addr,
  input  logic [1:0]         addr_len,
  input  logic [LEN_W-1:0]   xfer_len,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               present,
  output logic [LEN_W-1:0]   fail_cnt,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [7:0]         wr_data,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [7:0]         rd_data,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [1:0]         cmd_op,
  output logic [7:0]         cmd_data,
  output logic               cmd_nack,
  input  logic               rsp_valid,
  input  logic               rsp_nack,
  input  logic [7:0]         rsp_data
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  phase_t             ph;
  logic               wait_rsp;
  xfer_op_t           op_q;
  logic [6:0]         chip_q;
  logic [MADDR_W-1:0] maddr_q;
  logic [1:0]         alen_q;
  logic [1:0]         aidx_q;
  logic [LEN_W-1:0]   left_q;
  logic [7:0]         rd_q;
  logic               err_q, present_q;

  logic [6:0] chip_fold, chip_read;
  logic [7:0] addr_byte;
  logic       accept_go, got_rsp, tally_hit;

  i2cs_addr_fold #(.MADDR_W(MADDR_W), .OVF_MASK(OVF_MASK)) u_fold (
    .chip(chip_q), .maddr(maddr_q), .alen(alen_q), .idx(aidx_q),
    .chip_out(chip_fold), .addr_byte(addr_byte)
  );

  assign accept_go = start && (ph == PH_IDLE);
  assign got_rsp   = wait_rsp && rsp_valid;
  assign tally_hit = got_rsp && (ph == PH_WDATA) && rsp_nack;

  i2cs_nack_tally #(.W(LEN_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(accept_go), .hit(tally_hit), .count(fail_cnt)
  );

  assign chip_read = (op_q == XF_PROBE) ? chip_q : chip_fold;

  // command presented to the engine for the current phase
  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = ENG_START;
    cmd_data  = 8'h00;
    cmd_nack  = 1'b0;
    wr_ready  = 1'b0;
    if (!wait_rsp) begin
      unique case (ph)
        PH_START1, PH_START2: begin
          cmd_valid = 1'b1;
          cmd_op    = ENG_START;
        end
        PH_MIDSTOP, PH_ENDSTOP: begin
          cmd_valid = 1'b1;
          cmd_op    = ENG_STOP;
        end
        PH_CHIPW: begin
          cmd_valid = 1'b1;
          cmd_op    = ENG_WRITE;
          cmd_data  = {chip_fold, 1'b0};
        end
        PH_CHIPR: begin
          cmd_valid = 1'b1;
          cmd_op    = ENG_WRITE;
          cmd_data  = {chip_read, 1'b1};
        end
        PH_ADDR: begin
          cmd_valid = 1'b1;
          cmd_op    = ENG_WRITE;
          cmd_data  = addr_byte;
        end
        PH_RDATA: begin
          cmd_valid = 1'b1;
          cmd_op    = ENG_READ;
          cmd_nack  = (left_q == ONE);
        end
        PH_WDATA: begin
          cmd_valid = wr_valid;
          cmd_op    = ENG_WRITE;
          cmd_data  = wr_data;
          wr_ready  = cmd_ready;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      wait_rsp  <= 1'b0;
      op_q      <= XF_WRITE;
      chip_q    <= '0;
      maddr_q   <= '0;
      alen_q    <= '0;
      aidx_q    <= '0;
      left_q    <= '0;
      rd_q      <= '0;
      err_q     <= 1'b0;
      present_q <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) wait_rsp <= 1'b1;
      if (got_rsp) wait_rsp <= 1'b0;

      unique case (ph)
        PH_IDLE: if (accept_go) begin
          op_q      <= xfer_op_t'(xfer_op);
          chip_q    <= chip_addr;
          maddr_q   <= mem_addr;
          alen_q    <= addr_len;
          left_q    <= xfer_len;
          err_q     <= 1'b0;
          present_q <= 1'b0;
          ph        <= PH_START1;
        end
        PH_START1: if (got_rsp) begin
          if (op_q == XF_PROBE || (op_q == XF_READ && alen_q == 2'd0)) ph <= PH_CHIPR;
          else ph <= PH_CHIPW;
        end
        PH_CHIPW: if (got_rsp) begin
          if (rsp_nack) begin
            err_q <= 1'b1;
            ph    <= PH_ENDSTOP;
          end else if (alen_q != 2'd0) begin
            aidx_q <= alen_q - 2'd1;
            ph     <= PH_ADDR;
          end else begin
            ph <= (left_q == '0) ? PH_ENDSTOP : PH_WDATA;
          end
        end
        PH_ADDR: if (got_rsp) begin
          if (rsp_nack) begin
            err_q <= 1'b1;
            ph    <= PH_DONE;
          end else if (aidx_q != 2'd0) begin
            aidx_q <= aidx_q - 2'd1;
          end else if (op_q == XF_READ) begin
            ph <= PH_MIDSTOP;
          end else begin
            ph <= (left_q == '0) ? PH_ENDSTOP : PH_WDATA;
          end
        end
        PH_MIDSTOP: if (got_rsp) ph <= PH_START2;
        PH_START2:  if (got_rsp) ph <= PH_CHIPR;
        PH_CHIPR: if (got_rsp) begin
          if (op_q == XF_PROBE) begin
            present_q <= !rsp_nack;
            ph        <= PH_ENDSTOP;
          end else begin
            ph <= (left_q == '0) ? PH_ENDSTOP : PH_RDATA;
          end
        end
        PH_RDATA: if (got_rsp) begin
          rd_q <= rsp_data;
          ph   <= PH_RDOUT;
        end
        PH_RDOUT: if (rd_ready) begin
          left_q <= left_q - ONE;
          ph     <= (left_q == ONE) ? PH_ENDSTOP : PH_RDATA;
        end
        PH_WDATA: if (got_rsp) begin
          left_q <= left_q - ONE;
          if (left_q == ONE) ph <= PH_ENDSTOP;
        end
        PH_ENDSTOP: if (got_rsp) ph <= PH_DONE;
        PH_DONE:    ph <= PH_IDLE;
        default:    ph <= PH_IDLE;
      endcase
    end
  end

  assign busy     = (ph != PH_IDLE);
  assign done     = (ph == PH_DONE);
  assign err      = err_q;
  assign present  = present_q;
  assign rd_valid = (ph == PH_RDOUT);
  assign rd_data  = rd_q;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_data,
  input logic       cmd_nack
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_valid && !rd_valid && !wr_ready));

  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data) && $stable(cmd_nack)));

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_rd_stalls_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cmd_valid);

  p_wr_to_engine_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |-> (cmd_valid && cmd_ready && cmd_op == 2'b10 && cmd_data == wr_data));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_then_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind i2c_xfer_seq i2cs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_data(cmd_data), .cmd_nack(cmd_nack)
);

// File: tb/tb_i2c_xfer_seq.sv
module tb_i2c_xfer_seq;
  localparam logic [6:0] MASK = 7'h03;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0;
  logic [1:0]  r_op = 2'd0;
  logic [6:0]  r_chip = 7'd0;
  logic [23:0] r_maddr = 24'd0;
  logic [1:0]  r_alen = 2'd0;
  logic [7:0]  r_len = 8'd0;
  logic        busy, done, err, present;
  logic [7:0]  fail_cnt;
  logic        wr_valid, wr_ready, rd_valid, rd_ready;
  logic [7:0]  wr_data, rd_data;
  logic        cmd_valid, cmd_ready, cmd_nack;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_data;
  logic        rsp_valid, rsp_nack;
  logic [7:0]  rsp_data;

  i2c_xfer_seq #(.MADDR_W(24), .LEN_W(8), .OVF_MASK(MASK)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_op(r_op), .chip_addr(r_chip),
    .mem_addr(r_maddr), .addr_len(r_alen), .xfer_len(r_len),
    .busy(busy), .done(done), .err(err), .present(present), .fail_cnt(fail_cnt),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_nack(cmd_nack),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_data(rsp_data)
  );

  int checks = 0;
  int failures = 0;

  logic [63:0] script = 64'd0;
  logic [7:0]  wbuf [16];
  int          wr_total = 0;

  // engine stub: logs every accepted command, answers after a short delay
  logic [1:0] log_op  [64];
  logic [7:0] log_dat [64];
  logic       log_nk  [64];
  int         log_n;
  logic       pend;
  int         pend_idx, dly;

  always @(posedge clk) begin
    if (clr) begin
      log_n <= 0; pend <= 1'b0; rsp_valid <= 1'b0; cmd_ready <= 1'b0;
      rsp_nack <= 1'b0; rsp_data <= 8'h00; dly <= 0; pend_idx <= 0;
    end else begin
      rsp_valid <= 1'b0;
      if (cmd_valid && cmd_ready) begin
        if (log_n < 64) begin
          log_op[log_n] <= cmd_op; log_dat[log_n] <= cmd_data; log_nk[log_n] <= cmd_nack;
        end
        log_n <= log_n + 1; pend <= 1'b1; pend_idx <= log_n;
        dly <= int'($urandom % 3); cmd_ready <= 1'b0;
      end else if (pend) begin
        if (dly == 0) begin
          rsp_valid <= 1'b1;
          rsp_nack  <= script[pend_idx[5:0]];
          rsp_data  <= 8'hA0 + 8'(pend_idx);
          pend      <= 1'b0;
        end else dly <= dly - 1;
      end else cmd_ready <= (($urandom % 4) != 0);
    end
  end

  int wr_idx;
  always @(posedge clk) begin
    if (clr) begin
      wr_idx <= 0; wr_valid <= 1'b0;
    end else if (wr_valid && wr_ready) begin
      wr_idx <= wr_idx + 1; wr_valid <= 1'b0;
    end else if (!wr_valid && wr_idx < wr_total && ($urandom % 2) == 1) begin
      wr_valid <= 1'b1;
    end
  end
  assign wr_data = wbuf[wr_idx[3:0]];

  logic [7:0] rd_got [16];
  int         rd_n;
  always @(posedge clk) begin
    if (clr) begin
      rd_n <= 0; rd_ready <= 1'b0;
    end else begin
      if (rd_valid && rd_ready) begin
        rd_got[rd_n[3:0]] <= rd_data; rd_n <= rd_n + 1;
      end
      rd_ready <= (($urandom % 3) != 0);
    end
  end

  // expected command list built from the requirements
  logic [1:0] exp_op  [64];
  logic [7:0] exp_dat [64];
  logic       exp_nk  [64];
  int         exp_n;
  logic       e_err, e_present;
  int         e_fail;
  logic [7:0] e_rd [16];
  int         e_rdn;

  task automatic push(input logic [1:0] op, input logic [7:0] d, input logic nk);
    exp_op[exp_n] = op; exp_dat[exp_n] = d; exp_nk[exp_n] = nk; exp_n++;
  endtask

  task automatic build_exp(input logic [1:0] op, input logic [6:0] chip, input logic [23:0] ma,
                           input logic [1:0] al, input logic [7:0] ln);
    logic [6:0] cf;
    logic [23:0] sh;
    exp_n = 0; e_err = 1'b0; e_present = 1'b0; e_fail = 0; e_rdn = 0;
    sh = ma >> (8 * al);
    cf = chip | (sh[6:0] & MASK);
    push(2'd0, 8'h00, 1'b0);
    if (op == 2'd2) begin
      push(2'd2, {chip, 1'b1}, 1'b0);
      e_present = !script[exp_n-1];
      push(2'd1, 8'h00, 1'b0);
      return;
    end
    if (!(op == 2'd1 && al == 2'd0)) begin
      push(2'd2, {cf, 1'b0}, 1'b0);
      if (script[exp_n-1]) begin
        e_err = 1'b1; push(2'd1, 8'h00, 1'b0); return;
      end
      for (int i = int'(al) - 1; i >= 0; i--) begin
        push(2'd2, ma[i*8 +: 8], 1'b0);
        if (script[exp_n-1]) begin e_err = 1'b1; return; end
      end
      if (op == 2'd1) begin
        push(2'd1, 8'h00, 1'b0);
        push(2'd0, 8'h00, 1'b0);
      end
    end
    if (op == 2'd1) begin
      push(2'd2, {cf, 1'b1}, 1'b0);
      for (int j = 0; j < int'(ln); j++) begin
        e_rd[e_rdn] = 8'hA0 + 8'(exp_n); e_rdn++;
        push(2'd3, 8'h00, (j == int'(ln) - 1));
      end
    end else begin
      for (int j = 0; j < int'(ln); j++) begin
        push(2'd2, wbuf[j], 1'b0);
        if (script[exp_n-1]) e_fail++;
      end
    end
    push(2'd1, 8'h00, 1'b0);
  endtask

  task automatic check(input logic ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  task automatic run(input logic [1:0] op, input logic [6:0] chip, input logic [23:0] ma,
                     input logic [1:0] al, input logic [7:0] ln, input string tag,
                     input logic stray);
    int cyc;
    int mis;
    build_exp(op, chip, ma, al, ln);
    wr_total = (op == 2'd0) ? int'(ln) : 0;
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    r_op = op; r_chip = chip; r_maddr = ma; r_alen = al; r_len = ln; start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy === 1'b1, "R11 busy after start", int'(busy), 1);
    if (stray) begin
      r_op = 2'd2; r_chip = ~chip; r_alen = 2'd0; start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    cyc = 0;
    while (done !== 1'b1 && cyc < 5000) begin
      @(negedge clk); cyc++;
    end
    check(cyc < 5000, {tag, " transfer completes"}, cyc, 0);
    check(err === e_err, {tag, " err status (R2/R3 abort rule)"}, int'(err), int'(e_err));
    if (op == 2'd0) check(int'(fail_cnt) == e_fail, "R7 data NACK count", int'(fail_cnt), e_fail);
    if (op == 2'd2) check(present === e_present, "R9 probe present", int'(present), int'(e_present));
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R11 done single cycle then idle", int'({done, busy}), 0);
    mis = -1;
    for (int k = 0; k < exp_n; k++) begin
      if (mis < 0 && (k >= log_n || log_op[k] !== exp_op[k] || log_dat[k] !== exp_dat[k] || log_nk[k] !== exp_nk[k]))
        mis = k;
    end
    if (log_n != exp_n && mis < 0) mis = exp_n;
    check(mis < 0, {tag, " command order (first mismatch index / count)"}, (mis < 0) ? log_n : mis, exp_n);
    if (op == 2'd1) begin
      mis = -1;
      for (int k = 0; k < e_rdn; k++) if (mis < 0 && rd_got[k] !== e_rd[k]) mis = k;
      check(rd_n == e_rdn && mis < 0, "R6 read stream data", rd_n, e_rdn);
    end
  endtask

  initial begin
    #(8 * 190000);
    failures++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) wbuf[i] = 8'h30 + 8'(i * 7);
    clr = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; clr = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && done === 1'b0 && cmd_valid === 1'b0 && rd_valid === 1'b0 && wr_ready === 1'b0,
          "R1 idle after reset", int'({busy, done, cmd_valid, rd_valid, wr_ready}), 0);

    // R7 write, all ACKed, alen 1
    script = 64'd0;
    run(2'd0, 7'h50, 24'h000012, 2'd1, 8'd3, "R7", 1'b0);
    // R7 data NACKs at commands 3 and 5 do not abort
    script = 64'h28;
    run(2'd0, 7'h50, 24'h000044, 2'd1, 8'd4, "R7", 1'b0);
    check(log_n == 8 && log_op[7] == 2'd1, "R7 stop after last byte", log_n, 8);
    // R2 device NACK -> stop, err
    script = 64'h2;
    run(2'd0, 7'h21, 24'h000000, 2'd2, 8'd2, "R2", 1'b0);
    check(log_n == 3 && log_op[2] == 2'd1, "R2 stop after device NACK", log_n, 3);
    // R3 offset NACK on second byte -> err, no stop
    script = 64'h8;
    run(2'd1, 7'h21, 24'h00ABCD, 2'd2, 8'd2, "R3", 1'b0);
    check(log_n == 4 && log_op[3] == 2'd2, "R3 no stop after offset NACK", log_n, 4);
    // R4 read with two offset bytes, plus stray start (R10)
    script = 64'd0;
    run(2'd1, 7'h2A, 24'h001234, 2'd2, 8'd4, "R4 R10", 1'b1);
    check(log_dat[2] == 8'h12 && log_dat[3] == 8'h34, "R3 offset MSB first", int'({log_dat[2], log_dat[3]}), 16'h1234);
    check(log_op[4] == 2'd1 && log_op[5] == 2'd0 && log_dat[6] == {7'h2A, 1'b1}, "R4 stop, start, read address",
          int'(log_dat[6]), int'({7'h2A, 1'b1}));
    // R5 read with offset length zero
    run(2'd1, 7'h11, 24'h000000, 2'd0, 8'd3, "R5", 1'b0);
    check(log_op[1] == 2'd2 && log_dat[1] == {7'h11, 1'b1}, "R5 direct read address", int'(log_dat[1]), int'({7'h11, 1'b1}));
    // R6 single byte read gets NACK
    run(2'd1, 7'h11, 24'h000007, 2'd1, 8'd1, "R6", 1'b0);
    check(log_op[6] == 2'd3 && log_nk[6] == 1'b1, "R6 last read NACKed", int'(log_nk[6]), 1);
    // R8 overflow folding: offset 0x3A5, one byte sent, bits 9:8 fold in
    run(2'd1, 7'h50, 24'h0003A5, 2'd1, 8'd2, "R8", 1'b0);
    check(log_dat[1] == {7'h53, 1'b0} && log_dat[2] == 8'hA5, "R8 folded device address",
          int'(log_dat[1]), int'({7'h53, 1'b0}));
    // R9 probe present / absent
    script = 64'd0;
    run(2'd2, 7'h3C, 24'hFFFFFF, 2'd2, 8'd0, "R9", 1'b0);
    script = 64'h2;
    run(2'd2, 7'h3C, 24'h000000, 2'd0, 8'd0, "R9", 1'b0);

    // constrained random mix
    for (int t = 0; t < 14; t++) begin
      logic [1:0] op;
      op = 2'($urandom % 3);
      for (int k = 0; k < 64; k++) script[k] = (($urandom % 6) == 0);
      for (int k = 0; k < 16; k++) wbuf[k] = 8'($urandom);
      run(op, 7'($urandom), 24'($urandom), 2'($urandom % 3), 8'($urandom % 7),
          (op == 2'd0) ? "R7 random" : (op == 2'd1) ? "R4 R5 R6 R8 random" : "R9 random", 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule